// File: doc/BRIEF.md
# Frame-Referenced DDR Word Aligner

This block rebuilds parallel sample words from a group of double-data-rate serial lanes that share one bit clock. Each lane arrives as a pair of single-bit signals per bit-clock cycle: the bit captured on the rising edge and the bit captured on the falling edge. The capture is done by an upstream DDR input register. A companion frame lane goes through the same capture path. It runs at one sixth of the bit clock, and its 0-to-1 transition marks the first bit of every 12-bit sample.

Every lane, including the frame lane, is shifted into a two-word history register. One shared offset selects a 12-bit window out of each history, in half-bit steps. A slip controller compares the frame lane's window against the pattern a correctly framed word must show. It moves the shared offset one half-bit at a time until the frame transition falls exactly on a word boundary. It then raises a lock flag. Once per word period, all lane words are presented side by side with a one-cycle valid strobe.

Top module: `frame_ddr_aligner`

## Requirements
- R1: In each bit-clock cycle a lane's rising-edge bit comes earlier in the serial stream than its falling-edge bit. The earliest bit of a sample, the one that coincides with the frame 0-to-1 transition, is placed at word bit 11 (the MSB).
- R2: `word_valid` is high for exactly one cycle in every 6 bit-clock cycles. It carries all lane words at once, and lane k sits in `word_bus[12k+11:12k]`. `word_bus` does not change while `word_valid` is low.
- R3: The window offset moves by exactly one half-bit position per slip and wraps from 11 back to 0. The same offset applies to every data lane and to the frame lane.
- R4: After a slip, the next 2 word periods are not judged. The earliest following slip comes on the third word after it.
- R5: Lock is declared after 4 consecutive judged frame windows equal 111111000000 (bits 11 down to 0). Lock can only be gained on a word period whose frame window matches.
- R6: While `locked` is high, each lane word equals the newest complete sample of that lane whose last bit was applied to the inputs before the clock edge preceding the edge that raises `word_valid`.
- R7: While locked, a single mismatching frame window does not drop lock. Two consecutive mismatching windows clear `locked`, and the search resumes.
- R8: During reset `locked`, `word_valid` and `word_bus` are all zero, and the offset starts at 0.
- R9: For any frame phase (0 to 11 half-bits), lock is reached within 40 word periods of reset. The offset does not move while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_rise | input | 8 | Rising-edge bit per data lane |
| lane_fall | input | 8 | Falling-edge bit per data lane |
| frame_rise | input | 1 | Rising-edge sample of the frame signal |
| frame_fall | input | 1 | Falling-edge sample of the frame signal |
| word_bus | output | 96 | Aligned words, 12 bits per lane |
| word_valid | output | 1 | One-cycle strobe per word period |
| locked | output | 1 | Frame boundary found and held |

## Verification
The assertions check several properties on every cycle:
- the offset stays within range and only ever advances by one step with wrap;
- slips are spaced by the settle window;
- lock is gained or lost only on a word period with a matching or mismatching frame window;
- the output words hold between strobes, and each history register takes in its lane's two bits in order.

Bit ordering, word content and alignment for every frame phase can only be shown by the bench's scenarios. So can the lock-time bound, tolerance of a single glitched frame bit, and loss and recovery of lock when the frame disappears. The bench serializes its own sample words and compares each aligned output against them.

// File: rtl/fdwa_pkg.sv
package fdwa_pkg;

  typedef enum logic {
    ST_SEEK = 1'b0,
    ST_HOLD = 1'b1
  } align_st_t;

  // Next half-bit offset, wrapping at the word length.
  function automatic int unsigned slip_next(input int unsigned ofs, input int unsigned word_w);
    return (ofs == word_w - 1) ? 0 : ofs + 1;
  endfunction

endpackage

// File: rtl/fdwa_lane_hist.sv
module fdwa_lane_hist #(
  parameter int HIST_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_rise,
  input  logic              bit_fall,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;

  // Newest bits at the bottom: rise is older than fall in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= {hist_q[HIST_W-3:0], bit_rise, bit_fall};
  end

  assign hist = hist_q;

  p_hist_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (hist_q[1:0] == $past({bit_rise, bit_fall})));

endmodule

// File: rtl/fdwa_window.sv
module fdwa_window #(
  parameter int HIST_W = 24,
  parameter int WORD_W = 12,
  parameter int OFS_W  = 4
) (
  input  logic [HIST_W-1:0] hist,
  input  logic [OFS_W-1:0]  ofs,
  output logic [WORD_W-1:0] word
);

  function automatic logic [WORD_W-1:0] pick(input logic [HIST_W-1:0] h,
                                              input logic [OFS_W-1:0]  o);
    logic [HIST_W-1:0] sh;
    sh = h >> o;
    return sh[WORD_W-1:0];
  endfunction

  assign word = pick(hist, ofs);

endmodule

// File: rtl/fdwa_slip_ctrl.sv
module fdwa_slip_ctrl
  import fdwa_pkg::*;
#(
  parameter int WORD_W       = 12,
  parameter int LOCK_WORDS   = 4,
  parameter int LOSS_WORDS   = 2,
  parameter int SETTLE_WORDS = 2,
  parameter int OFS_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [WORD_W-1:0] frame_word,
  output logic [OFS_W-1:0]  ofs,
  output logic              locked,
  output logic              slip_evt,
  output logic              frame_ok
);

  localparam int CNT_W = $clog2(LOCK_WORDS + LOSS_WORDS + SETTLE_WORDS + 2);
  localparam logic [WORD_W-1:0] FRAME_PAT =
    {{(WORD_W - WORD_W/2){1'b1}}, {(WORD_W/2){1'b0}}};

  align_st_t        st_q;
  logic [OFS_W-1:0] ofs_q;
  logic [CNT_W-1:0] settle_q, good_q, bad_q, since_q;
  logic             check_evt, lock_evt, loss_evt;

  assign frame_ok  = (frame_word == FRAME_PAT);
  assign check_evt = tick && (st_q == ST_SEEK) && (settle_q == '0);
  assign slip_evt  = check_evt && !frame_ok;
  assign lock_evt  = check_evt && frame_ok && (good_q == CNT_W'(LOCK_WORDS - 1));
  assign loss_evt  = tick && (st_q == ST_HOLD) && !frame_ok && (bad_q == CNT_W'(LOSS_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_SEEK;
      ofs_q    <= '0;
      settle_q <= CNT_W'(SETTLE_WORDS);
      good_q   <= '0;
      bad_q    <= '0;
    end else if (tick) begin
      case (st_q)
        ST_SEEK: begin
          if (settle_q != '0) begin
            settle_q <= settle_q - 1'b1;
          end else if (slip_evt) begin
            ofs_q    <= OFS_W'(slip_next(int'(ofs_q), WORD_W));
            settle_q <= CNT_W'(SETTLE_WORDS);
            good_q   <= '0;
          end else if (lock_evt) begin
            st_q   <= ST_HOLD;
            good_q <= '0;
            bad_q  <= '0;
          end else begin
            good_q <= good_q + 1'b1;
          end
        end
        default: begin
          if (frame_ok) begin
            bad_q <= '0;
          end else if (loss_evt) begin
            st_q     <= ST_SEEK;
            bad_q    <= '0;
            good_q   <= '0;
            settle_q <= '0;
          end else begin
            bad_q <= bad_q + 1'b1;
          end
        end
      endcase
    end
  end

  // Word periods since the last slip, saturating; observation only.
  always_ff @(posedge clk) begin
    if (!rst_n)                                      since_q <= '0;
    else if (slip_evt)                               since_q <= '0;
    else if (tick && since_q < CNT_W'(SETTLE_WORDS)) since_q <= since_q + 1'b1;
  end

  assign ofs    = ofs_q;
  assign locked = (st_q == ST_HOLD);

  p_ofs_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_q < OFS_W'(WORD_W));

  p_slip_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_q != $past(ofs_q)) |->
      (ofs_q == (($past(ofs_q) == OFS_W'(WORD_W - 1)) ? '0 : $past(ofs_q) + 1'b1)));

  p_settle_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slip_evt |-> (since_q >= CNT_W'(SETTLE_WORDS)));

  p_lock_on_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(tick && frame_ok));

  p_loss_on_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(tick && !frame_ok));

  p_hold_ofs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(ofs_q));

endmodule

// File: rtl/frame_ddr_aligner.sv
module frame_ddr_aligner #(
  parameter int LANES        = 8,
  parameter int WORD_W       = 12,
  parameter int LOCK_WORDS   = 4,
  parameter int LOSS_WORDS   = 2,
  parameter int SETTLE_WORDS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        lane_rise,
  input  logic [LANES-1:0]        lane_fall,
  input  logic                    frame_rise,
  input  logic                    frame_fall,
  output logic [LANES*WORD_W-1:0] word_bus,
  output logic                    word_valid,
  output logic                    locked
);

  localparam int CYC    = WORD_W / 2;
  localparam int HIST_W = 2 * WORD_W;
  localparam int OFS_W  = $clog2(WORD_W);
  localparam int PH_W   = $clog2(CYC);

  logic [PH_W-1:0]   phase_q;
  logic              tick;
  logic [OFS_W-1:0]  ofs;
  logic              slip_evt, frame_ok;
  logic [LANES:0]    rise_all, fall_all;
  logic [WORD_W-1:0] win [LANES+1];
  logic [LANES*WORD_W-1:0] word_q;
  logic              valid_q;

  // Word period counter in bit-clock cycles.
  always_ff @(posedge clk) begin
    if (!rst_n)                          phase_q <= '0;
    else if (phase_q == PH_W'(CYC - 1))  phase_q <= '0;
    else                                 phase_q <= phase_q + 1'b1;
  end
  assign tick = (phase_q == PH_W'(CYC - 1));

  // Index LANES is the frame lane; it shares the offset with the data lanes.
  assign rise_all = {frame_rise, lane_rise};
  assign fall_all = {frame_fall, lane_fall};

  for (genvar g = 0; g <= LANES; g++) begin : g_lane
    logic [HIST_W-1:0] hist;
    fdwa_lane_hist #(.HIST_W(HIST_W)) u_hist (
      .clk(clk), .rst_n(rst_n),
      .bit_rise(rise_all[g]), .bit_fall(fall_all[g]),
      .hist(hist)
    );
    fdwa_window #(.HIST_W(HIST_W), .WORD_W(WORD_W), .OFS_W(OFS_W)) u_win (
      .hist(hist), .ofs(ofs), .word(win[g])
    );
  end

  fdwa_slip_ctrl #(
    .WORD_W(WORD_W), .LOCK_WORDS(LOCK_WORDS), .LOSS_WORDS(LOSS_WORDS),
    .SETTLE_WORDS(SETTLE_WORDS), .OFS_W(OFS_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .frame_word(win[LANES]),
    .ofs(ofs), .locked(locked), .slip_evt(slip_evt), .frame_ok(frame_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= tick;
      if (tick) begin
        for (int k = 0; k < LANES; k++) word_q[k*WORD_W +: WORD_W] <= win[k];
      end
    end
  end

  assign word_bus   = word_q;
  assign word_valid = valid_q;

  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  p_bus_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_bus));

  p_slip_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slip_evt |-> !locked);

  p_ok_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frame_ok) |-> (win[LANES][WORD_W-1] && !win[LANES][0]));

endmodule

// File: tb/frame_ddr_aligner_tb_top.sv
module frame_ddr_aligner_tb_top;

  localparam int LANES = 8;
  localparam int W     = 12;
  localparam int HW    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [LANES-1:0]   lane_rise = '0, lane_fall = '0;
  logic               frame_rise = 1'b0, frame_fall = 1'b0;
  logic [LANES*W-1:0] word_bus;
  logic               word_valid, locked;

  frame_ddr_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .lane_rise(lane_rise), .lane_fall(lane_fall),
    .frame_rise(frame_rise), .frame_fall(frame_fall),
    .word_bus(word_bus), .word_valid(word_valid), .locked(locked)
  );

  int checks = 0, failures = 0, cyc = 0;
  int ph = 0, hb = 0, mode = 0, wcnt = 0;
  int last_valid = -1, valids = 0;
  bit glitch_arm = 0, frame_kill = 0, data_chk = 0, lock_lost = 0;
  logic [W-1:0] cur [LANES];
  logic [W-1:0] done_now [LANES];
  logic [W-1:0] d1 [LANES];
  logic [W-1:0] d2 [LANES];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pick_word(input int lane, input int n);
    case (mode)
      1:       return ((n + lane) % 2 == 1) ? 12'hFFF : 12'h000;
      2:       return W'((12'h001 << (n % W)) ^ (lane * 12'h111));
      default: return W'($urandom);
    endcase
  endfunction

  // Next half-bit of the serial stream on every lane, MSB of each sample first.
  task automatic half_bit(output logic [LANES-1:0] b, output logic fb);
    int pos;
    pos = (hb + ph) % W;
    if (pos == 0) begin
      for (int l = 0; l < LANES; l++) cur[l] = pick_word(l, wcnt);
      wcnt++;
    end
    for (int l = 0; l < LANES; l++) b[l] = cur[l][W-1-pos];
    fb = (pos < HW);
    if (glitch_arm && pos == 3) begin
      fb = ~fb;
      glitch_arm = 0;
    end
    if (frame_kill) fb = 1'b0;
    if (pos == W - 1) for (int l = 0; l < LANES; l++) done_now[l] = cur[l];
    hb++;
  endtask

  task automatic step();
    logic [LANES-1:0] r, f;
    logic fr, ff;
    @(negedge clk);
    cyc++;
    if (rst_n && !locked) lock_lost = 1;
    if (rst_n && word_valid) begin
      valids++;
      if (last_valid >= 0)
        chk(cyc - last_valid == 6, "R2", "valid spacing", cyc - last_valid, 6);
      last_valid = cyc;
      if (data_chk && locked)
        for (int l = 0; l < LANES; l++)
          chk(word_bus[l*W +: W] == d2[l], "R1 R6", $sformatf("lane %0d word", l),
              word_bus[l*W +: W], d2[l]);
    end
    half_bit(r, fr);
    half_bit(f, ff);
    lane_rise = r; lane_fall = f; frame_rise = fr; frame_fall = ff;
    for (int l = 0; l < LANES; l++) begin
      d2[l] = d1[l];
      d1[l] = done_now[l];
    end
  endtask

  task automatic reset_run(input int p, input int m);
    ph = p; mode = m;
    rst_n = 1'b0; data_chk = 0; last_valid = -1;
    repeat (3) step();
    chk(word_valid == 1'b0, "R8", "valid in reset", word_valid, 0);
    chk(locked == 1'b0, "R8", "locked in reset", locked, 0);
    chk(word_bus == '0, "R8", "bus in reset", (word_bus != '0), 0);
    rst_n = 1'b1;
    valids = 0;
  endtask

  task automatic wait_lock(input bit bound);
    int n;
    n = 0;
    while (!locked && n < 1200) begin
      step();
      n++;
    end
    chk(locked == 1'b1, "R5 R9", $sformatf("lock reached phase %0d", ph), locked, 1);
    if (bound)
      chk(valids >= 6 && valids <= 40, "R3 R4 R5 R9", "word periods to lock", valids, 40);
  endtask

  task automatic run_words(input int n);
    data_chk = 1;
    repeat (n * 6) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all actual=%0d expected=%0d", 150000, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int rp;
    rp = int'($urandom(32'd2024));
    for (int l = 0; l < LANES; l++) begin
      cur[l] = '0; done_now[l] = '0; d1[l] = '0; d2[l] = '0;
    end
    // Directed phases, including odd half-bit offsets (R3) and the wrap end.
    reset_run(0, 0);  wait_lock(1); run_words(10);
    reset_run(5, 1);  wait_lock(1); run_words(10);
    reset_run(7, 2);  wait_lock(1); run_words(10);
    reset_run(11, 0); wait_lock(1); run_words(10);
    reset_run(1, 1);  wait_lock(1); run_words(10);
    // Random phases with random data.
    for (int i = 0; i < 3; i++) begin
      rp = int'($urandom % W);
      reset_run(rp, 0); wait_lock(1); run_words(12);
    end
    // R7: one glitched frame bit keeps lock and data.
    lock_lost = 0;
    glitch_arm = 1;
    run_words(5);
    chk(lock_lost == 0, "R7", "lock kept after one bad word", lock_lost, 0);
    // R7: frame gone for several words drops lock.
    frame_kill = 1;
    data_chk = 0;
    repeat (4 * 6) step();
    chk(locked == 1'b0, "R7", "lock dropped after bad words", locked, 0);
    frame_kill = 0;
    wait_lock(0);
    run_words(10);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule